// File: doc/BRIEF.md
# Programmable Tap Delay Controller

This block delays a single-bit data stream by a chosen number of clock cycles. The data is shifted every cycle through a tapped shift register, and a multiplexer picks one tap. The chosen tap goes to a registered output. A ten-bit select word sets the tap. The word can track its inputs each cycle, or it can be frozen by a hold control.

Two override inputs act on the held word. One clears the word to the shortest delay. The other sets it to one step beyond the largest value the word can code. The clearing override wins when both are high.

An active-low gate forces the output low. An extra select bit is captured under the same hold rule and driven out so that a following stage can extend the range. Several stages can be chained this way.

Top module: `tap_delay_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, dout is 0 after that edge. The held word, the beyond-maximum flag and the held cascade bit are cleared, so with hold high and no override after reset the delay code is 0 and casc_out is 0.
- R2: With hold low and both overrides low, the delay code equals sel, read as an unsigned number with bit 0 least significant. After each edge, dout equals the din that was sampled N edges earlier, where N is the code. Code 0 gives one register of latency.
- R3: With hold high and both overrides low, the code keeps the value in force at the last edge where hold was low or an override was high. Changes on sel have no effect on dout.
- R4: When force_min is high, the code is 0 for that cycle. The held word and flag are cleared, so the code stays 0 afterwards while hold stays high.
- R5: When force_max is high and force_min is low, the code is 1024 (one beyond 1023) for that cycle. This setting is held and stays in force afterwards while hold stays high.
- R6: When force_min and force_max are both high, force_min wins and the code is 0.
- R7: When gate_n is high at an edge, dout is 0 after that edge. When gate_n is low, dout is the delayed data.
- R8: casc_out follows sel_ext while hold is low. While hold is high, casc_out keeps the sel_ext value captured at the last edge with hold low. The overrides do not affect it.
- R9: The shift register moves on every cycle whatever the code is, so after a code change the output at once shows the data from N edges earlier. Taps are not flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Data stream to be delayed |
| sel | input | 10 | Delay select word, bit 0 is the LSB |
| sel_ext | input | 1 | Extra select bit, routed to the cascade output |
| hold | input | 1 | 0: select tracks its inputs, 1: select is frozen |
| force_min | input | 1 | Clears the select to the shortest delay (highest priority) |
| force_max | input | 1 | Sets the select to one step beyond all-ones |
| gate_n | input | 1 | Active-low output enable; high forces dout low |
| dout | output | 1 | Delayed data, registered |
| casc_out | output | 1 | Cascade bit for a following stage |

## Verification
Two functions can land on the same edge: a change of the applied code (an override pulse, or hold being released) and the output gate opening or closing. The bench changes gate_n and the select controls on the same cycles. It also pulses both overrides together while hold is high. For every cycle it works out the code from its own model of the hold and override priority, and predicts dout from a history of the data it has driven. The release of an override is judged on the first edge after it, where the held setting alone must decide the tap.

// File: rtl/tdc_pkg.sv
// Package: shared types for the tap delay controller.
// Assumes: nothing beyond IEEE 1800-2017.
package tdc_pkg;
    // Which source decides the applied delay code, in decreasing priority.
    typedef enum logic [1:0] {
        SRC_MIN  = 2'd0,
        SRC_MAX  = 2'd1,
        SRC_PASS = 2'd2,
        SRC_HELD = 2'd3
    } code_src_e;
endpackage

// File: rtl/tdc_sel_latch.sv
// Select latch: works out the applied delay code from the select word,
// the hold control and the two overrides. It also keeps the cascade bit.
// Assumes: the clearing override has priority over the setting override.
// The beyond-maximum setting is stored as a flag next to the all-ones word.
module tdc_sel_latch
    import tdc_pkg::*;
#(
    parameter int SEL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             sel_ext,
    input  logic             hold,
    input  logic             force_min,
    input  logic             force_max,
    output logic [SEL_W:0]   code,
    output logic             casc
);
    localparam int CODE_W = SEL_W + 1;
    localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(1) << SEL_W;

    code_src_e        src;
    logic [SEL_W-1:0] held_q;
    logic             beyond_q;
    logic             casc_q;

    // Priority decode of the code source.
    always_comb begin
        if (force_min)      src = SRC_MIN;
        else if (force_max) src = SRC_MAX;
        else if (!hold)     src = SRC_PASS;
        else                src = SRC_HELD;
    end

    // Held word and beyond-maximum flag, updated by the overrides or by tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q   <= '0;
            beyond_q <= 1'b0;
        end else begin
            unique case (src)
                SRC_MIN: begin
                    held_q   <= '0;
                    beyond_q <= 1'b0;
                end
                SRC_MAX: begin
                    held_q   <= '1;
                    beyond_q <= 1'b1;
                end
                SRC_PASS: begin
                    held_q   <= sel;
                    beyond_q <= 1'b0;
                end
                default: begin
                    held_q   <= held_q;
                    beyond_q <= beyond_q;
                end
            endcase
        end
    end

    // Applied code for this cycle.
    always_comb begin
        unique case (src)
            SRC_MIN:  code = '0;
            SRC_MAX:  code = MAX_CODE;
            SRC_PASS: code = {1'b0, sel};
            default:  code = beyond_q ? MAX_CODE : {1'b0, held_q};
        endcase
    end

    // Cascade bit storage; the overrides do not touch it.
    always_ff @(posedge clk) begin
        if (!rst_n)     casc_q <= 1'b0;
        else if (!hold) casc_q <= sel_ext;
    end

    // Cascade output: tracks the input while hold is low.
    always_comb casc = hold ? casc_q : sel_ext;
endmodule

// File: rtl/tdc_tap_line.sv
// Tap line: a shift register that moves on every clock, plus a tap
// multiplexer. Tap 0 is the live input; tap k is the input from k edges ago.
// Assumes: code never exceeds 2**SEL_W.
module tdc_tap_line #(
    parameter int SEL_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           din,
    input  logic [SEL_W:0] code,
    output logic           tap_bit
);
    localparam int NREG  = 1 << SEL_W;
    localparam int NTAPS = NREG + 1;

    logic [NREG-1:0]  sr_q;
    logic [NTAPS-1:0] taps;

    // Shift the input in every cycle; taps are never flushed.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[NREG-2:0], din};
    end

    // Put the taps together, with the live input in the lowest place.
    always_comb taps = {sr_q, din};

    // Select the tap given by the code.
    always_comb tap_bit = taps[code];
endmodule

// File: rtl/tdc_out_stage.sv
// Output stage: registers the chosen tap and applies the active-low gate.
// Assumes: the gate is sampled on the same edge as the data.
module tdc_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic tap_bit,
    input  logic gate_n,
    output logic dout
);
    logic dout_q;

    // Registered, gated output.
    always_ff @(posedge clk) begin
        if (!rst_n)      dout_q <= 1'b0;
        else if (gate_n) dout_q <= 1'b0;
        else             dout_q <= tap_bit;
    end

    // Drive the port.
    always_comb dout = dout_q;
endmodule

// File: rtl/tap_delay_ctrl.sv
// Top: programmable tap delay controller. Connects the select latch, the
// tap line and the output stage.
// Assumes: synchronous active-low reset; all inputs synchronous to clk.
module tap_delay_ctrl #(
    parameter int SEL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    input  logic             sel_ext,
    input  logic             hold,
    input  logic             force_min,
    input  logic             force_max,
    input  logic             gate_n,
    output logic             dout,
    output logic             casc_out
);
    logic [SEL_W:0] eff_code;
    logic           tap_bit;

    tdc_sel_latch #(.SEL_W(SEL_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sel_ext(sel_ext),
        .hold(hold), .force_min(force_min), .force_max(force_max),
        .code(eff_code), .casc(casc_out)
    );

    tdc_tap_line #(.SEL_W(SEL_W)) u_line (
        .clk(clk), .rst_n(rst_n), .din(din), .code(eff_code),
        .tap_bit(tap_bit)
    );

    tdc_out_stage u_out (
        .clk(clk), .rst_n(rst_n), .tap_bit(tap_bit), .gate_n(gate_n),
        .dout(dout)
    );
endmodule

// File: rtl/tap_delay_ctrl_chk.sv
// Checker: temporal properties of the tap delay controller, bound to the top.
module tap_delay_ctrl_chk #(
    parameter int SEL_W = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           din,
    input logic           hold,
    input logic           force_min,
    input logic           force_max,
    input logic           gate_n,
    input logic [SEL_W:0] eff_code,
    input logic           dout,
    input logic           casc_out
);
    localparam logic [SEL_W:0] MAX_CODE = (SEL_W+1)'(1) << SEL_W;

    // R7
    gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_n |=> !dout);

    // R4
    min_tap0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_min && !gate_n) |=> dout == $past(din));

    // R6
    both_min_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_min && force_max && !gate_n) |=> dout == $past(din));

    // R5
    max_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_max && !force_min) |=>
        ((hold && !force_min && !force_max) -> eff_code == MAX_CODE));

    // R8
    casc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |-> $stable(casc_out));

    // R3
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !force_min && !force_max && $past(hold)
         && !$past(force_min) && !$past(force_max)) |-> $stable(eff_code));
endmodule

bind tap_delay_ctrl tap_delay_ctrl_chk #(.SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .din(din), .hold(hold),
    .force_min(force_min), .force_max(force_max), .gate_n(gate_n),
    .eff_code(eff_code), .dout(dout), .casc_out(casc_out)
);

// File: tb/sim_tap_delay_ctrl.sv
`timescale 1ns/1ps
module sim_tap_delay_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b0;
    logic [9:0] sel = '0;
    logic       sel_ext = 1'b0;
    logic       hold = 1'b1;
    logic       force_min = 1'b0;
    logic       force_max = 1'b0;
    logic       gate_n = 1'b0;
    logic       dout;
    logic       casc_out;

    int checks = 0;
    int errors = 0;

    // Bench model of the requirements
    bit hist[$];
    int m_held = 0;
    bit m_beyond = 0;
    bit m_casc = 0;

    tap_delay_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .din(din), .sel(sel), .sel_ext(sel_ext),
        .hold(hold), .force_min(force_min), .force_max(force_max),
        .gate_n(gate_n), .dout(dout), .casc_out(casc_out)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: controls already set; drive d, predict, check after edge.
    task automatic step(input bit d, input string tag);
        int code;
        bit exp_d;
        din = d;
        if (force_min)      code = 0;
        else if (force_max) code = 1024;
        else if (!hold)     code = int'(sel);
        else                code = m_beyond ? 1024 : m_held;
        hist.push_front(d);
        if (hist.size() > 1100) void'(hist.pop_back());
        exp_d = gate_n ? 1'b0 : ((code < hist.size()) ? hist[code] : 1'b0);
        if (force_min)      begin m_held = 0; m_beyond = 0; end
        else if (force_max) begin m_held = 1023; m_beyond = 1; end
        else if (!hold)     begin m_held = int'(sel); m_beyond = 0; end
        if (!hold) m_casc = sel_ext;
        @(posedge clk);
        #2;
        chk(tag, dout, exp_d);
        chk("R8 cascade", casc_out, hold ? m_casc : sel_ext);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; hold = 1'b1; force_min = 0; force_max = 0; gate_n = 0;
        din = 1'b1; sel = 10'd500; sel_ext = 1'b1;
        repeat (3) begin
            @(posedge clk); #2;
            chk("R1 reset dout", dout, 1'b0);
            chk("R1 reset casc", casc_out, 1'b0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        hist.delete(); m_held = 0; m_beyond = 0; m_casc = 0;
        for (int i = 0; i < 4; i++) step(i[0], "R1 code zero after reset");
    endtask

    task automatic t_pass();
        int codes[5] = '{0, 1, 2, 7, 100};
        hold = 1'b0;
        foreach (codes[k]) begin
            sel = 10'(codes[k]);
            for (int i = 0; i < codes[k] + 40; i++) step(1'($urandom), "R2 pass-through");
        end
    endtask

    task automatic t_hold();
        hold = 1'b0; sel = 10'd13;
        for (int i = 0; i < 30; i++) step(1'($urandom), "R2 before hold");
        hold = 1'b1;
        for (int i = 0; i < 60; i++) begin
            sel = 10'($urandom);
            step(1'($urandom), "R3 hold ignores sel");
        end
    endtask

    task automatic t_min();
        force_min = 1'b1;
        for (int i = 0; i < 2; i++) step(1'($urandom), "R4 min override");
        force_min = 1'b0;
        for (int i = 0; i < 40; i++) begin
            sel = 10'($urandom);
            step(1'($urandom), "R4 min kept");
        end
    endtask

    task automatic t_max();
        force_max = 1'b1;
        step(1'($urandom), "R5 max override");
        force_max = 1'b0;
        for (int i = 0; i < 1100; i++) step(1'($urandom), "R5 beyond max kept");
    endtask

    task automatic t_both();
        force_min = 1'b1; force_max = 1'b1;
        for (int i = 0; i < 30; i++) step(1'($urandom), "R6 min over max");
        force_max = 1'b0;
        for (int i = 0; i < 10; i++) step(1'($urandom), "R6 min kept");
        force_min = 1'b0;
    endtask

    task automatic t_gate();
        hold = 1'b0; sel = 10'd3;
        for (int i = 0; i < 80; i++) begin
            gate_n = 1'($urandom);
            if (i % 9 == 0) sel = 10'($urandom_range(0, 20));
            step(1'($urandom), "R7 gate");
        end
        gate_n = 1'b0;
    endtask

    task automatic t_casc();
        for (int i = 0; i < 80; i++) begin
            hold = 1'($urandom);
            sel_ext = 1'($urandom);
            force_min = (i % 11 == 0);
            force_max = (i % 7 == 0);
            step(1'($urandom), "R8 cascade cycle");
        end
        force_min = 0; force_max = 0;
    endtask

    task automatic t_change();
        hold = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (i % 5 == 0) sel = 10'($urandom_range(0, 50));
            step(1'($urandom), "R9 code change no flush");
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_pass();
        t_hold();
        t_min();
        t_max();
        t_both();
        t_gate();
        t_casc();
        t_change();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule